// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose write side and read side run on clocks that have no fixed relation to each other. Words of `DATA_W` bits enter on the write clock when the write enable is high. They leave in the same order on the read clock when the read enable is high. The block reports its fill level through five active-low flags: empty, almost-empty, half-full, almost-full and full. Two parameters set the thresholds of the two "almost" flags.

A master reset clears the buffer and sets every flag to its empty-state level. While the reset is held, the block samples a timing-mode input. With the input high, each threshold flag is owned by one clock. Almost-full is a write-clock register and almost-empty is a read-clock register. With the input low, each threshold flag follows the live difference of the two raw pointers. It is set by an edge of one clock and released by an edge of the other. Empty, full and half-full are always registered in their own domain. Each of them is computed from the local pointer and the other side's pointer, which crosses the clock boundary as Gray code through a two-stage synchronizer.

Top module: `dual_clk_flag_fifo`

## Requirements
- R1: `flag_mode_i` is captured only while `mrst` is high. 1 selects single-clock threshold flags and 0 selects cross-clock threshold flags. Changing the input after reset does not change the behaviour.
- R2: While `mrst` is high on both clocks, both pointers clear. The flags then read full_n=1, afull_n=1, half_n=1, aempty_n=0, empty_n=0. `rd_data` reads 0.
- R3: `empty_n` is low exactly when no word is stored. A read request while `empty_n` is low is dropped, and `rd_data` keeps its previous value.
- R4: With EMPTY_OFS = n, `aempty_n` is low for a fill of 0 to n words and high from n+1 words upward.
- R5: `half_n` is low once the fill reaches DEPTH/2 + 1 words (513 with the default DEPTH of 1024), and is high below that.
- R6: With FULL_OFS = m, `afull_n` is low for a fill from DEPTH−m up to DEPTH (897 to 1024 by default). `full_n` is low only at DEPTH words. A write request while `full_n` is low is dropped and stores nothing.
- R7: Words are read in write order. An accepted read presents its word on `rd_data` after the same read-clock rising edge that accepts it.
- R8: In single-clock mode, `afull_n` changes only on write-clock edges and `aempty_n` changes only on read-clock edges. A stopped clock therefore freezes its flag.
- R9: In cross-clock mode, a write-clock edge can drive `afull_n` low and a read-clock edge can return it high. A read-clock edge can drive `aempty_n` low and a write-clock edge can return it high. Each change is visible right after that edge, even while the other clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, active high, synchronous in each domain |
| flag_mode_i | input | 1 | Threshold-flag timing select, sampled during reset (1 single-clock, 0 cross-clock) |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Word most recently read |
| full_n | output | 1 | Full, active low |
| afull_n | output | 1 | Almost-full, active low |
| half_n | output | 1 | Half-full, active low |
| aempty_n | output | 1 | Almost-empty, active low |
| empty_n | output | 1 | Empty, active low |

## Verification
A result in the requesting clock's own domain is due right after the rising edge that accepts the request. This covers read data, empty, full, half-full and the single-clock threshold flags, for their own side's change. The cross-clock threshold flags also follow the edge at once. A change made by the other domain reaches empty, full, half-full and the single-clock flags only after two synchronizer edges and one flag-register edge. The bench therefore samples every result on the falling edge that follows the causing rising edge. Before it compares fill-level flags, it waits a settle time of more than ten edges of both clocks. For the per-edge checks of R8 and R9 it stops one clock, so that only the other clock can have caused the change it observes.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic {
        TIMING_CROSS  = 1'b0,
        TIMING_SINGLE = 1'b1
    } flag_timing_e;

    typedef struct packed {
        logic full_n;
        logic afull_n;
        logic half_n;
    } wr_flags_t;

    typedef struct packed {
        logic aempty_n;
        logic empty_n;
    } rd_flags_t;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W      = 11,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage[s] <= '0;
        end else begin
            stage[0] <= d;
            for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int DATA_W = 36,
    parameter int DEPTH  = 1024,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rrst)    rdata <= '0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int DEPTH    = 1024,
    parameter int FULL_OFS = 127,
    localparam int ADDR_W  = $clog2(DEPTH),
    localparam int PTR_W   = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_in,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  rgray_s,
    output logic [PTR_W-1:0]  wbin,
    output logic [PTR_W-1:0]  wgray,
    output logic              mem_we,
    output logic [ADDR_W-1:0] waddr,
    output wr_flags_t         flags,
    output flag_timing_e      mode_q
);
    localparam logic [PTR_W-1:0] FULL_LVL  = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] HALF_LVL  = PTR_W'(DEPTH / 2 + 1);
    localparam logic [PTR_W-1:0] AFULL_LVL = PTR_W'(DEPTH - FULL_OFS);

    logic [PTR_W-1:0] rbin_s;
    logic [PTR_W-1:0] wbin_nx;
    logic [PTR_W-1:0] fill_nx;

    assign mem_we  = wr_en && flags.full_n;
    assign waddr   = wbin[ADDR_W-1:0];
    assign rbin_s  = PTR_W'(from_gray(32'(rgray_s)));
    assign wbin_nx = wbin + PTR_W'(mem_we);
    assign fill_nx = wbin_nx - rbin_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin   <= '0;
            wgray  <= '0;
            flags  <= '{full_n: 1'b1, afull_n: 1'b1, half_n: 1'b1};
            mode_q <= flag_timing_e'(mode_in);
        end else begin
            wbin          <= wbin_nx;
            wgray         <= PTR_W'(to_gray(32'(wbin_nx)));
            flags.full_n  <= (fill_nx != FULL_LVL);
            flags.half_n  <= (fill_nx < HALF_LVL);
            flags.afull_n <= (fill_nx < AFULL_LVL);
        end
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flags.full_n) |=> $stable(wbin));
    p_full_has_afull_r6: assert property (@(posedge clk) disable iff (rst)
        !flags.full_n |-> !flags.afull_n);
    p_full_has_half_r5: assert property (@(posedge clk) disable iff (rst)
        !flags.full_n |-> !flags.half_n);
    p_mode_hold_w_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(mode_q));
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int DEPTH     = 1024,
    parameter int EMPTY_OFS = 127,
    localparam int ADDR_W   = $clog2(DEPTH),
    localparam int PTR_W    = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_in,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  wgray_s,
    output logic [PTR_W-1:0]  rbin,
    output logic [PTR_W-1:0]  rgray,
    output logic              mem_re,
    output logic [ADDR_W-1:0] raddr,
    output rd_flags_t         flags,
    output flag_timing_e      mode_q
);
    localparam logic [PTR_W-1:0] AEMPTY_LVL = PTR_W'(EMPTY_OFS);

    logic [PTR_W-1:0] wbin_s;
    logic [PTR_W-1:0] rbin_nx;
    logic [PTR_W-1:0] fill_nx;

    assign mem_re  = rd_en && flags.empty_n;
    assign raddr   = rbin[ADDR_W-1:0];
    assign wbin_s  = PTR_W'(from_gray(32'(wgray_s)));
    assign rbin_nx = rbin + PTR_W'(mem_re);
    assign fill_nx = wbin_s - rbin_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin   <= '0;
            rgray  <= '0;
            flags  <= '{aempty_n: 1'b0, empty_n: 1'b0};
            mode_q <= flag_timing_e'(mode_in);
        end else begin
            rbin           <= rbin_nx;
            rgray          <= PTR_W'(to_gray(32'(rbin_nx)));
            flags.empty_n  <= (fill_nx != '0);
            flags.aempty_n <= (fill_nx > AEMPTY_LVL);
        end
    end

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !flags.empty_n) |=> $stable(rbin));
    p_empty_has_aempty_r4: assert property (@(posedge clk) disable iff (rst)
        !flags.empty_n |-> !flags.aempty_n);
    p_mode_hold_r_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(mode_q));
endmodule

// File: rtl/dual_clk_flag_fifo.sv
module dual_clk_flag_fifo
    import dcf_pkg::*;
#(
    parameter int DATA_W    = 36,
    parameter int DEPTH     = 1024,
    parameter int EMPTY_OFS = 127,
    parameter int FULL_OFS  = 127
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mrst,
    input  logic              flag_mode_i,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full_n,
    output logic              afull_n,
    output logic              half_n,
    output logic              aempty_n,
    output logic              empty_n
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;
    localparam logic [PTR_W-1:0] AFULL_LVL  = PTR_W'(DEPTH - FULL_OFS);
    localparam logic [PTR_W-1:0] AEMPTY_LVL = PTR_W'(EMPTY_OFS);

    logic [PTR_W-1:0]  wbin, rbin, wgray, rgray, wgray_s, rgray_s;
    logic [PTR_W-1:0]  raw_fill;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              mem_we, mem_re;
    wr_flags_t         wf;
    rd_flags_t         rf;
    flag_timing_e      mode_w, mode_r;

    dcf_wr_side #(.DEPTH(DEPTH), .FULL_OFS(FULL_OFS)) u_wr (
        .clk(wr_clk), .rst(mrst), .mode_in(flag_mode_i), .wr_en(wr_en),
        .rgray_s(rgray_s), .wbin(wbin), .wgray(wgray), .mem_we(mem_we),
        .waddr(waddr), .flags(wf), .mode_q(mode_w)
    );

    dcf_rd_side #(.DEPTH(DEPTH), .EMPTY_OFS(EMPTY_OFS)) u_rd (
        .clk(rd_clk), .rst(mrst), .mode_in(flag_mode_i), .rd_en(rd_en),
        .wgray_s(wgray_s), .rbin(rbin), .rgray(rgray), .mem_re(mem_re),
        .raddr(raddr), .flags(rf), .mode_q(mode_r)
    );

    dcf_sync #(.W(PTR_W)) u_w2r (.clk(rd_clk), .rst(mrst), .d(wgray), .q(wgray_s));
    dcf_sync #(.W(PTR_W)) u_r2w (.clk(wr_clk), .rst(mrst), .d(rgray), .q(rgray_s));

    dcf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .wclk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
        .rclk(rd_clk), .rrst(mrst), .re(mem_re), .raddr(raddr), .rdata(rd_data)
    );

    // Cross-clock variant: live difference of both raw binary pointers.
    assign raw_fill = wbin - rbin;

    assign full_n   = wf.full_n;
    assign half_n   = wf.half_n;
    assign empty_n  = rf.empty_n;
    assign afull_n  = (mode_w == TIMING_SINGLE) ? wf.afull_n  : (raw_fill < AFULL_LVL);
    assign aempty_n = (mode_r == TIMING_SINGLE) ? rf.aempty_n : (raw_fill > AEMPTY_LVL);

    p_empty_read_holds_r3: assert property (@(posedge rd_clk) disable iff (mrst)
        (rd_en && !empty_n) |=> $stable(rd_data));
    p_single_afull_wr_r8: assert property (@(posedge wr_clk) disable iff (mrst)
        (mode_w == TIMING_SINGLE) |-> (afull_n == wf.afull_n));
endmodule

// File: tb/dual_clk_flag_fifo_tb.sv
module dual_clk_flag_fifo_tb;
    localparam int DW = 36;
    localparam int D  = 1024;

    logic wr_clk = 1'b0, rd_clk = 1'b0;
    logic wr_run = 1'b1, rd_run = 1'b1;
    logic mrst = 1'b1, flag_mode_i = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic full_n, afull_n, half_n, aempty_n, empty_n;

    int total = 0, bad = 0;
    int cnt = 0, wseq = 0, rseq = 0;
    logic [DW-1:0] last_rd = '0;

    dual_clk_flag_fifo u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .flag_mode_i(flag_mode_i),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .full_n(full_n), .afull_n(afull_n), .half_n(half_n),
        .aempty_n(aempty_n), .empty_n(empty_n)
    );

    // 50 MHz write clock, 33.3 MHz read clock; each stops low when disabled.
    always begin #10; if (wr_run || wr_clk) wr_clk = ~wr_clk; end
    always begin #15; if (rd_run || rd_clk) rd_clk = ~rd_clk; end

    // fields: writes[26:16], reads[15:5], flags {full,afull,half,aempty,empty}[4:0]
    localparam logic [26:0] VEC [13] = '{
        {11'd1,    11'd0,    5'b11101},   // 1 word: R3 R4
        {11'd126,  11'd0,    5'b11101},   // 127: still almost-empty R4
        {11'd1,    11'd0,    5'b11111},   // 128: R4 release
        {11'd385,  11'd0,    5'b11011},   // 513: R5
        {11'd0,    11'd1,    5'b11111},   // 512: R5
        {11'd385,  11'd0,    5'b10011},   // 897: R6
        {11'd0,    11'd1,    5'b11011},   // 896: R6
        {11'd127,  11'd0,    5'b10011},   // 1023: R6
        {11'd1,    11'd0,    5'b00011},   // 1024: R6 full
        {11'd1,    11'd0,    5'b00011},   // dropped write R6
        {11'd0,    11'd1024, 5'b11100},   // drain R7 R3
        {11'd0,    11'd1,    5'b11100},   // dropped read R3
        {11'd5,    11'd3,    5'b11101}    // 2 words left R7
    };

    function automatic logic [DW-1:0] pat(input int s);
        return {4'hA, 32'(s) ^ 32'h5A5A_0000};
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] flags();
        return {full_n, afull_n, half_n, aempty_n, empty_n};
    endfunction

    task automatic check_flags(input logic [4:0] exp, input string req);
        check(flags() === exp, req, 36'(flags()), 36'(exp));
    endtask

    task automatic do_reset(input bit m);
        wr_run = 1'b1; rd_run = 1'b1; #60;
        flag_mode_i = m;
        @(negedge wr_clk) mrst = 1'b1;
        repeat (4) @(posedge rd_clk);
        repeat (4) @(posedge wr_clk);
        @(negedge wr_clk) mrst = 1'b0;
        cnt = 0; rseq = wseq; last_rd = '0;
        #100;
    endtask

    task automatic write_words(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge wr_clk);
            wr_en = 1'b1;
            if (cnt < D) begin
                wr_data = pat(wseq); wseq++; cnt++;
            end else begin
                wr_data = 36'hD_EAD0_BEEF;
            end
        end
        if (k > 0) @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic read_words(input int k);
        if (k > 0) begin
            @(negedge rd_clk);
            rd_en = 1'b1;
            for (int i = 0; i < k; i++) begin
                @(negedge rd_clk);
                if (cnt > 0) begin
                    check(rd_data === pat(rseq), "R7 order", rd_data, pat(rseq));
                    last_rd = pat(rseq); rseq++; cnt--;
                end else begin
                    check(rd_data === last_rd, "R3 empty read dropped", rd_data, last_rd);
                end
            end
            rd_en = 1'b0;
        end
    endtask

    task automatic settle();
        #600;
    endtask

    task automatic stop_wr();  @(negedge wr_clk); wr_run = 1'b0; #60; endtask
    task automatic stop_rd();  @(negedge rd_clk); rd_run = 1'b0; #60; endtask
    task automatic go_wr();    wr_run = 1'b1; #40; endtask
    task automatic go_rd();    rd_run = 1'b1; #40; endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Almost-full edge ownership test (R8/R9); the mode input flips after reset (R1).
    task automatic afull_edges(input bit m);
        do_reset(m);
        flag_mode_i = ~m;
        write_words(896); settle();
        check(afull_n === 1'b1, "R6 896 words afull high", 36'(afull_n), 36'd1);
        stop_rd();
        write_words(1);
        check(afull_n === 1'b0, m ? "R8 afull low on wr edge" : "R9 afull low on wr edge",
              36'(afull_n), 36'd0);
        go_rd(); stop_wr();
        read_words(1);
        if (m) check(afull_n === 1'b0, "R8 R1 afull frozen without wr edge", 36'(afull_n), 36'd0);
        else   check(afull_n === 1'b1, "R9 afull released on rd edge", 36'(afull_n), 36'd1);
        go_wr(); settle();
        check(afull_n === 1'b1, "R8 R9 afull settled high", 36'(afull_n), 36'd1);
    endtask

    // Almost-empty edge ownership test (R8/R9).
    task automatic aempty_edges(input bit m);
        do_reset(m);
        flag_mode_i = ~m;
        write_words(128); settle();
        check(aempty_n === 1'b1, "R4 128 words aempty high", 36'(aempty_n), 36'd1);
        stop_wr();
        read_words(1);
        check(aempty_n === 1'b0, m ? "R8 aempty low on rd edge" : "R9 aempty low on rd edge",
              36'(aempty_n), 36'd0);
        go_wr(); stop_rd();
        write_words(1);
        if (m) check(aempty_n === 1'b0, "R8 R1 aempty frozen without rd edge", 36'(aempty_n), 36'd0);
        else   check(aempty_n === 1'b1, "R9 aempty released on wr edge", 36'(aempty_n), 36'd1);
        go_rd(); settle();
        check(aempty_n === 1'b1, "R8 R9 aempty settled high", 36'(aempty_n), 36'd1);
    endtask

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        // Table walk in both timing modes.
        for (int mode = 1; mode >= 0; mode--) begin
            do_reset(mode[0]);
            check_flags(5'b11100, "R2 reset flags");
            check(rd_data === '0, "R2 reset data", rd_data, '0);
            for (int v = 0; v < 13; v++) begin
                write_words(int'(VEC[v][26:16]));
                read_words(int'(VEC[v][15:5]));
                settle();
                check_flags(VEC[v][4:0], "R3 R4 R5 R6 flag table");
            end
        end

        // Reset with words stored: pointers and flags return to empty state (R2).
        write_words(600); settle();
        do_reset(1'b1);
        check_flags(5'b11100, "R2 reset after fill");
        write_words(1); settle();
        check_flags(5'b11101, "R2 one word after reset");
        read_words(1);

        afull_edges(1'b1);
        afull_edges(1'b0);
        aempty_edges(1'b1);
        aempty_edges(1'b0);

        finish_up();
    end
endmodule